// File: doc/BRIEF.md
# Dual-Channel Simultaneous-Sampling ADC Sequencer

This block sits on the host side of a two-channel, simultaneous-sampling, 12-bit successive-approximation converter with a serial output. It drives the convert-start strobe and the serial clock. It samples both converter data lines in parallel and returns two 12-bit results together with a single-cycle strobe. A short command port starts a conversion or runs a power-saving sequence. A partial sleep is selected by where the convert-start line rises inside the clock burst. A deep sleep is two partial-sleep frames in a row. Waking uses a long low convert-start burst, and after a deep sleep the block holds off for a settling interval.

The serial clock is the system clock divided by the even parameter `CLK_DIV`. Convert-start only moves while the serial clock is low. A conversion frame has sixteen rising clock edges, and the converter launches a new bit on each edge. The controller samples each bit on the following rising edge. The four leading zero bits fall out of the 12-bit shift register, so only D11..D0 remain.

The state machine has five states. ST_IDLE is awake and accepting commands. ST_BURST holds convert-start low and runs the clock. ST_HOLD holds convert-start high for half a clock period after a frame. ST_ASLEEP is powered down and accepts only wake. ST_SETTLE waits out the deep-sleep settling time. The transitions are:
- ST_IDLE to ST_BURST on convert, partial sleep or deep sleep.
- ST_BURST to ST_HOLD after the last falling edge of the frame.
- ST_HOLD to ST_IDLE after a conversion or a wake from partial sleep.
- ST_HOLD to ST_BURST for the second frame of a deep sleep.
- ST_HOLD to ST_ASLEEP after the final sleep frame.
- ST_HOLD to ST_SETTLE after a wake from deep sleep.
- ST_ASLEEP to ST_BURST on wake.
- ST_SETTLE to ST_IDLE when the timer expires.

Top module: `adc_dual_ctrl`

## Requirements
- R1: After reset, convert-start is high, the serial clock is low, busy is low, ready is high and the result strobe is low.
- R2: Command code 0 (convert) pulls convert-start low, produces exactly 16 rising serial clock edges while it is low, then raises it. The serial clock is never high while convert-start is high.
- R3: Each channel's result is the last 12 of the 16 bits sampled MSB first, one bit per rising serial clock edge, so the four leading zeros are dropped. Both results appear together with a result strobe one system clock wide. Results change only with the strobe.
- R4: Convert-start changes level only in cycles where the serial clock is low.
- R5: Command code 1 (partial sleep) raises convert-start after the SLEEP_EDGE-th rising edge (default 8, inside the allowed window of edges 3 to 13). After that, ready is low, busy is low and the serial clock stays low.
- R6: Command code 2 (deep sleep) runs two partial-sleep frames back to back, each with SLEEP_EDGE rising edges.
- R7: Command code 3 (wake), given while asleep, holds convert-start low for WAKE_EDGES (default 14) rising edges and then raises it. After a partial sleep, ready is high in the same cycle that busy falls.
- R8: After a wake from deep sleep, busy stays high and ready stays low for at least (CLK_HZ/1e6)*WAKE_US system clocks after convert-start rises. Then ready rises.
- R9: A command given while busy is ignored. Convert and sleep commands given while asleep are ignored. Wake given while awake is ignored. None of these produces a convert-start falling edge.
- R10: Whenever busy is low, the serial clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 2 | Command code: 0 convert, 1 partial sleep, 2 deep sleep, 3 wake |
| dout_a_i | input | 1 | Serial data from channel A |
| dout_b_i | input | 1 | Serial data from channel B |
| cnvst_o | output | 1 | Convert-start strobe to the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| res_a_o | output | 12 | Channel A result |
| res_b_o | output | 12 | Channel B result |
| res_valid_o | output | 1 | One-cycle strobe marking new results |
| busy_o | output | 1 | A frame or settling wait is in progress |
| ready_o | output | 1 | Converter is awake and settled |

## Verification
The hardest case to reach is the deep-sleep wake. The port has to see two back-to-back short frames, then a wake burst, then the full settling interval with busy held high. It must also be shown that no conversion can start before that interval ends. The bench drives this with a behavioural converter that decodes the convert-start rise position into its own sleep state. The model records the cycle at which it may next convert and counts any conversion that starts earlier. The settling time is shortened through the clock-frequency parameter so the complete wake sequence fits in the run.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

    typedef enum logic [1:0] {
        CMD_CONVERT  = 2'd0,
        CMD_PART_PD  = 2'd1,
        CMD_FULL_PD  = 2'd2,
        CMD_WAKE     = 2'd3
    } adc_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_BURST  = 3'd1,
        ST_HOLD   = 3'd2,
        ST_ASLEEP = 3'd3,
        ST_SETTLE = 3'd4
    } ctrl_state_e;

    typedef enum logic [1:0] {
        FR_CONV  = 2'd0,
        FR_SLEEP = 2'd1,
        FR_WAKE  = 2'd2
    } frame_e;

    localparam int unsigned FRAME_BITS = 16;
    localparam int unsigned RES_BITS   = 12;

endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
    parameter int unsigned HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic sclk_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt_q;
    logic          sclk_q;
    logic          term;

    assign term = (cnt_q == CW'(HALF - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
        end else if (!en_i) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
        end else if (term) begin
            cnt_q  <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign sclk_o = sclk_q;
    assign rise_o = en_i & term & ~sclk_q;
    assign fall_o = en_i & term & sclk_q;

endmodule

// File: rtl/adc_dual_capture.sv
module adc_dual_capture #(
    parameter int unsigned W  = 12,
    parameter int unsigned CH = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic            shift_i,
    input  logic [CH-1:0]   dout_i,
    output logic [CH*W-1:0] word_o
);
    // A W-bit shifter fed with the whole frame keeps only its last W bits,
    // which discards the leading zeros ahead of the MSB.
    for (genvar g = 0; g < CH; g++) begin : g_lane
        logic [W-1:0] sh_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       sh_q <= '0;
            else if (clr_i)   sh_q <= '0;
            else if (shift_i) sh_q <= {sh_q[W-2:0], dout_i[g]};
        end
        assign word_o[g*W +: W] = sh_q;
    end

endmodule

// File: rtl/adc_wake_timer.sv
module adc_wake_timer #(
    parameter int unsigned CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic done_o
);
    localparam int unsigned CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic          done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_i) begin
                cnt_q <= '0;
                run_q <= 1'b1;
            end else if (run_q) begin
                if (cnt_q == CW'(CYCLES - 1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign done_o = done_q;

endmodule

// File: rtl/adc_dual_ctrl.sv
module adc_dual_ctrl
    import adc_ctrl_pkg::*;
#(
    parameter int unsigned CLK_DIV    = 4,
    parameter int unsigned CLK_HZ     = 200_000_000,
    parameter int unsigned WAKE_US    = 2000,
    parameter int unsigned SLEEP_EDGE = 8,
    parameter int unsigned WAKE_EDGES = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid_i,
    input  logic [1:0]          cmd_i,
    input  logic                dout_a_i,
    input  logic                dout_b_i,
    output logic                cnvst_o,
    output logic                sclk_o,
    output logic [RES_BITS-1:0] res_a_o,
    output logic [RES_BITS-1:0] res_b_o,
    output logic                res_valid_o,
    output logic                busy_o,
    output logic                ready_o
);
    localparam int unsigned HALF     = CLK_DIV / 2;
    localparam int unsigned WAKE_CYC = (CLK_HZ / 1_000_000) * WAKE_US;
    localparam int unsigned MAX_E    = (WAKE_EDGES > FRAME_BITS) ? WAKE_EDGES : FRAME_BITS;
    localparam int unsigned EW       = $clog2(MAX_E + 1);
    localparam int unsigned HW       = (HALF > 1) ? $clog2(HALF) : 1;

    ctrl_state_e   state_q, state_d;
    frame_e        frame_q, frame_d;
    logic          second_q, second_d;
    logic          full_q, full_d;
    logic          awake_q, awake_d;
    logic [EW-1:0] edge_q;
    logic [HW-1:0] hold_q;
    logic [EW-1:0] limit;

    logic gen_en, rise, fall, last_fall, hold_done;
    logic timer_start, timer_done;
    logic cap_clr;
    logic [2*RES_BITS-1:0] words;

    adc_sclk_gen #(.HALF(HALF)) u_sclk (
        .clk(clk), .rst_n(rst_n), .en_i(gen_en),
        .sclk_o(sclk_o), .rise_o(rise), .fall_o(fall)
    );

    adc_dual_capture #(.W(RES_BITS), .CH(2)) u_cap (
        .clk(clk), .rst_n(rst_n), .clr_i(cap_clr),
        .shift_i(rise), .dout_i({dout_b_i, dout_a_i}), .word_o(words)
    );

    adc_wake_timer #(.CYCLES(WAKE_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .start_i(timer_start), .done_o(timer_done)
    );

    always_comb begin
        unique case (frame_q)
            FR_CONV:  limit = EW'(FRAME_BITS);
            FR_SLEEP: limit = EW'(SLEEP_EDGE);
            FR_WAKE:  limit = EW'(WAKE_EDGES);
            default:  limit = EW'(FRAME_BITS);
        endcase
    end

    assign last_fall = (state_q == ST_BURST) && fall && (edge_q == limit);
    assign hold_done = (hold_q == HW'(HALF - 1));

    // state register and frame context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            frame_q  <= FR_CONV;
            second_q <= 1'b0;
            full_q   <= 1'b0;
            awake_q  <= 1'b1;
        end else begin
            state_q  <= state_d;
            frame_q  <= frame_d;
            second_q <= second_d;
            full_q   <= full_d;
            awake_q  <= awake_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d     = state_q;
        frame_d     = frame_q;
        second_d    = second_q;
        full_d      = full_q;
        awake_d     = awake_q;
        timer_start = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid_i) begin
                    unique case (adc_cmd_e'(cmd_i))
                        CMD_CONVERT: begin
                            frame_d = FR_CONV;
                            state_d = ST_BURST;
                        end
                        CMD_PART_PD: begin
                            frame_d  = FR_SLEEP;
                            second_d = 1'b0;
                            full_d   = 1'b0;
                            awake_d  = 1'b0;
                            state_d  = ST_BURST;
                        end
                        CMD_FULL_PD: begin
                            frame_d  = FR_SLEEP;
                            second_d = 1'b1;
                            full_d   = 1'b1;
                            awake_d  = 1'b0;
                            state_d  = ST_BURST;
                        end
                        CMD_WAKE: ;
                    endcase
                end
            end
            ST_BURST: begin
                if (last_fall) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (hold_done) begin
                    unique case (frame_q)
                        FR_CONV: state_d = ST_IDLE;
                        FR_SLEEP: begin
                            if (second_q) begin
                                second_d = 1'b0;
                                state_d  = ST_BURST;
                            end else begin
                                state_d  = ST_ASLEEP;
                            end
                        end
                        FR_WAKE: begin
                            if (full_q) begin
                                timer_start = 1'b1;
                                state_d     = ST_SETTLE;
                            end else begin
                                awake_d = 1'b1;
                                state_d = ST_IDLE;
                            end
                        end
                        default: state_d = ST_IDLE;
                    endcase
                end
            end
            ST_ASLEEP: begin
                if (cmd_valid_i && (adc_cmd_e'(cmd_i) == CMD_WAKE)) begin
                    frame_d = FR_WAKE;
                    state_d = ST_BURST;
                end
            end
            ST_SETTLE: begin
                if (timer_done) begin
                    awake_d = 1'b1;
                    full_d  = 1'b0;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from the state register
    always_comb begin
        cnvst_o = (state_q != ST_BURST);
        gen_en  = (state_q == ST_BURST);
        cap_clr = (state_q != ST_BURST);
        busy_o  = !((state_q == ST_IDLE) || (state_q == ST_ASLEEP));
        ready_o = awake_q;
    end

    // edge and hold counters, result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_q      <= '0;
            hold_q      <= '0;
            res_a_o     <= '0;
            res_b_o     <= '0;
            res_valid_o <= 1'b0;
        end else begin
            if (state_q != ST_BURST) edge_q <= '0;
            else if (rise)           edge_q <= edge_q + 1'b1;

            if (state_q != ST_HOLD)  hold_q <= '0;
            else                     hold_q <= hold_q + 1'b1;

            res_valid_o <= 1'b0;
            if (last_fall && (frame_q == FR_CONV)) begin
                res_a_o     <= words[0 +: RES_BITS];
                res_b_o     <= words[RES_BITS +: RES_BITS];
                res_valid_o <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/adc_dual_ctrl_chk.sv
module adc_dual_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cnvst,
    input logic        sclk,
    input logic [11:0] res_a,
    input logic [11:0] res_b,
    input logic        valid,
    input logic        busy,
    input logic        ready
);
    AST_SCLK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cnvst);                                        // R2
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);                                       // R3
    AST_RES_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ((res_a != $past(res_a)) || (res_b != $past(res_b))) |-> valid); // R3
    AST_CNVST_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cnvst != $past(cnvst)) |-> !sclk);                      // R4
    AST_READY_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> !busy);                                 // R7
    AST_VALID_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ready);                                        // R9
    AST_IDLE_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);                                        // R10
endmodule

bind adc_dual_ctrl adc_dual_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cnvst(cnvst_o), .sclk(sclk_o),
    .res_a(res_a_o), .res_b(res_b_o), .valid(res_valid_o),
    .busy(busy_o), .ready(ready_o)
);

// File: tb/adc_dual_ctrl_test.sv
module adc_dual_ctrl_test;
    localparam int DIV      = 4;
    localparam int HZ       = 1_000_000;
    localparam int WUS      = 2000;
    localparam int WAKE_CYC = (HZ / 1_000_000) * WUS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd = 2'd0;
    logic        dout_a = 1'b0, dout_b = 1'b0;
    logic        cnvst, sclk, valid, busy, ready;
    logic [11:0] res_a, res_b;

    always #2.5 clk = ~clk;

    adc_dual_ctrl #(.CLK_DIV(DIV), .CLK_HZ(HZ), .WAKE_US(WUS)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
        .dout_a_i(dout_a), .dout_b_i(dout_b), .cnvst_o(cnvst), .sclk_o(sclk),
        .res_a_o(res_a), .res_b_o(res_b), .res_valid_o(valid),
        .busy_o(busy), .ready_o(ready)
    );

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    // behavioural converter: mode 0 awake, 1 partial sleep, 2 deep sleep
    int          cyc = 0;
    int          m_mode = 0, m_edges = 0, last_edges = 0, m_falls = 0;
    int          ready_at = 0, early = 0, cnv_rise_cyc = 0;
    logic [11:0] val_a = '0, val_b = '0;
    logic [15:0] sh_a = '0, sh_b = '0;

    always @(posedge clk) cyc++;

    always @(negedge cnvst or posedge sclk) begin
        if (sclk) begin
            m_edges++;
            #1;
            sh_a = sh_a << 1; sh_b = sh_b << 1;
            dout_a = sh_a[15]; dout_b = sh_b[15];
        end else begin
            m_edges = 0;
            m_falls++;
            if (m_mode == 0) begin
                if (cyc < ready_at) early++;
                sh_a = {4'b0, val_a}; sh_b = {4'b0, val_b};
            end else begin
                sh_a = '0; sh_b = '0;
            end
            dout_a = sh_a[15]; dout_b = sh_b[15];
        end
    end

    always @(posedge cnvst) begin
        last_edges   = m_edges;
        cnv_rise_cyc = cyc;
        if (m_edges >= 3 && m_edges <= 13 && m_mode < 2) m_mode = m_mode + 1;
        else if (m_edges >= 14 && m_mode != 0) begin
            if (m_mode == 2) ready_at = cyc + WAKE_CYC;
            m_mode = 0;
        end
    end

    // port monitors
    int   valid_cnt = 0, valid_long = 0, order_bad = 0;
    logic prev_valid = 0, prev_cnvst = 1;
    logic [11:0] got_a, got_b;
    always @(negedge clk) begin
        if (valid) begin
            valid_cnt++;
            got_a = res_a; got_b = res_b;
            if (prev_valid) valid_long++;
        end
        if (rst_n && cnvst != prev_cnvst && sclk) order_bad++;
        prev_valid = valid;
        prev_cnvst = cnvst;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] c);
        @(negedge clk); cmd_valid = 1'b1; cmd = c;
        @(negedge clk); cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(cnvst == 1, "R1 cnvst", cnvst, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(sclk == 0, "R1 sclk", sclk, 0);
        chk(busy == 0, "R1 busy", busy, 0);
        chk(ready == 1, "R1 ready", ready, 1);
        chk(valid == 0, "R1 valid", valid, 0);
    endtask

    task automatic t_convert(input logic [11:0] a, input logic [11:0] b);
        int v0;
        val_a = a; val_b = b; v0 = valid_cnt;
        issue(2'd0);
        wait_idle();
        repeat (2) @(negedge clk);
        chk(valid_cnt == v0 + 1, "R3 strobe count", valid_cnt - v0, 1);
        chk(got_a == a, "R3 result A", got_a, a);
        chk(got_b == b, "R3 result B", got_b, b);
        chk(last_edges == 16, "R2 edges", last_edges, 16);
        chk(valid_long == 0, "R3 strobe width", valid_long, 0);
        chk(order_bad == 0, "R4 cnvst vs sclk", order_bad, 0);
    endtask

    task automatic t_busy_ignore();
        int f0;
        val_a = 12'h5A5; val_b = 12'h0F0; f0 = m_falls;
        issue(2'd0);
        repeat (6) @(negedge clk);
        cmd_valid = 1'b1; cmd = 2'd1;
        @(negedge clk); cmd_valid = 1'b0;
        wait_idle();
        repeat (4) @(negedge clk);
        chk(m_falls == f0 + 1, "R9 busy cmd frames", m_falls - f0, 1);
        chk(m_mode == 0 && ready == 1, "R9 busy cmd mode", m_mode, 0);
        chk(got_a == 12'h5A5, "R9 busy conv A", got_a, 12'h5A5);
    endtask

    task automatic t_partial();
        int f0;
        issue(2'd1);
        wait_idle();
        chk(last_edges == 8, "R5 sleep edges", last_edges, 8);
        chk(m_mode == 1, "R5 model mode", m_mode, 1);
        chk(ready == 0, "R5 ready", ready, 0);
        repeat (20) @(negedge clk);
        chk(sclk == 0 && busy == 0, "R10 sclk asleep", sclk, 0);
        f0 = m_falls;
        issue(2'd0); repeat (10) @(negedge clk);
        issue(2'd2); repeat (10) @(negedge clk);
        chk(m_falls == f0 && busy == 0, "R9 asleep ignore", m_falls - f0, 0);
        issue(2'd3);
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
        chk(ready == 1, "R7 ready with idle", ready, 1);
        chk(last_edges == 14 && m_mode == 0, "R7 wake edges", last_edges, 14);
    endtask

    task automatic t_full();
        int f0, rise_c, dly;
        f0 = m_falls;
        issue(2'd2);
        wait_idle();
        chk(m_falls == f0 + 2, "R6 frame count", m_falls - f0, 2);
        chk(m_mode == 2 && last_edges == 8, "R6 deep mode", m_mode, 2);
        issue(2'd3);
        @(posedge cnvst); rise_c = cyc;
        repeat (WAKE_CYC / 2) @(negedge clk);
        chk(busy == 1 && ready == 0, "R8 held mid-wait", busy, 1);
        for (int i = 0; i < 3 * WAKE_CYC; i++) begin
            @(negedge clk);
            if (ready) break;
        end
        dly = cyc - rise_c;
        chk(dly >= WAKE_CYC && dly <= WAKE_CYC + DIV + 4, "R8 wake delay", dly, WAKE_CYC);
        t_convert(12'hFFF, 12'h001);
        chk(early == 0, "R8 early convert", early, 0);
    endtask

    task automatic t_wake_awake();
        int f0;
        f0 = m_falls;
        issue(2'd3);
        repeat (40) @(negedge clk);
        chk(m_falls == f0 && busy == 0 && sclk == 0, "R9 wake while awake", m_falls - f0, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_convert(12'hABC, 12'h123);
        t_convert(12'h800, 12'h7FF);
        t_busy_ignore();
        t_wake_awake();
        t_partial();
        t_convert(12'h3C3, 12'hC3C);
        t_full();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end
endmodule